// File: doc/BRIEF.md
# Banked 40-Source Interrupt Controller

This block gathers forty level-sensitive interrupt lines into two banks: a 32-bit bank for sources 0 to 31 and an 8-bit bank for sources 32 to 39. Each source has an enable bit and a steering bit. The steering bit sends an enabled, active source either to the fast output `fiq_o` (steering 1) or to the normal output `irq_o` (steering 0). Software reads filtered views of the pending state and programs the enables and steering through a byte-addressed register port. A second port, addressed by a 4-bit index, reaches a subset of the same registers.

When the attached core reports that it is halted, the block raises `wake_o` for any active source that is enabled. If the idle override is on, it raises `wake_o` for any active source at all. The block stores forty priority entries and presents them to an external resolver. It does not rank sources itself. The resolver's result comes back on `hp_word_i` and can be read through either port.

Both ports are plain and never stall. A write takes effect at the next rising clock edge. Read data is a combinational function of the address and the current state, so no back-pressure exists on either port.

Top module: `intc_banked40`

## Requirements
- R1: Source n for n below 32 appears at bit n of bank 0. Source n from 32 to 39 appears at bit n-32 of bank 1. The unfiltered pending state is read at offset 0x10 for bank 0 and 0xAC for bank 1.
- R2: Each pending bit equals its input line as sampled at the previous rising clock edge. It clears as soon as a low level is sampled, with no latching.
- R3: The enable registers are at 0x04 (bank 0) and 0xA0 (bank 1). The steering registers are at 0x08 and 0xA4. All four are read/write, and bank 1 uses data bits 7:0.
- R4: The normal view (0x00 and 0x9C) reads pending AND enable AND NOT steering. The fast view (0x0C and 0xA8) reads pending AND enable AND steering.
- R5: `fiq_o` is 1 exactly when some bit of pending AND enable AND steering is set in either bank. `irq_o` is 1 exactly when some bit of pending AND enable AND NOT steering is set in either bank. Both follow register state without further delay.
- R6: Writing control offset 0x14 with bit 0 = 1 turns the idle override off. Writing it with bit 0 = 0 turns the override on. A read returns 1 when the override is off and 0 when it is on. Reset leaves the override off.
- R7: `wake_o` is 1 exactly when `core_halted_i` is 1 and, in either bank, pending AND (enable OR override) is nonzero.
- R8: Priority entry k (0..31) is at 0x1C+4k, and entry k (32..39) is at 0xB0+4(k-32). A write stores only data bit 31 and bits 5:0, so the value read back is the write data ANDed with 0x8000003F. `prio_tbl_o[7k+6:7k]` carries {bit 31, bits 5:0} of entry k.
- R9: Reset clears pending, enable and steering in both banks and all priority entries.
- R10: Coprocessor indices 0x0 to 0xA select, in this order: normal view, enable, steering, fast view and raw pending of bank 0; the highest-priority word; then normal view, enable, steering, fast view and raw pending of bank 1. Indices 0xB to 0xF read 0 and ignore writes.
- R11: Offsets that are unassigned or not multiples of 4 read 0, and writes to them change nothing. Writes to the pending views, the raw pending registers and the highest-priority offset are ignored.
- R12: Offset 0x18, and coprocessor index 0x5, return `hp_word_i` unchanged.
- R13: If both ports write in the same cycle, both writes take effect. When both target the same register, the coprocessor port's data is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| src_i | input | 40 | Interrupt source lines, active high |
| core_halted_i | input | 1 | Core is halted |
| bus_wr_i | input | 1 | Register port write strobe |
| bus_addr_i | input | 8 | Register port byte offset |
| bus_wdata_i | input | 32 | Register port write data |
| bus_rdata_o | output | 32 | Register port read data (combinational) |
| cp_wr_i | input | 1 | Coprocessor port write strobe |
| cp_idx_i | input | 4 | Coprocessor register index |
| cp_wdata_i | input | 32 | Coprocessor port write data |
| cp_rdata_o | output | 32 | Coprocessor port read data (combinational) |
| hp_word_i | input | 32 | Highest-priority word from the external resolver |
| prio_tbl_o | output | 280 | Forty 7-bit priority entries for the resolver |
| fiq_o | output | 1 | Fast interrupt request |
| irq_o | output | 1 | Normal interrupt request |
| wake_o | output | 1 | Wake request for a halted core |

## Verification
The assertions assume that every input is a known 0 or 1 at each rising edge once reset is released. They also assume that a write strobe is never left high while its address or index is changing. The stimulus changes inputs only on falling edges and drops each strobe after exactly one rising edge. It raises both strobes together only in the scenario aimed at R13. The read-only and unmapped-write checks keep the other port idle, so the state under test can be changed by only one source.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int NSRC   = 40;
  localparam int BANK_W = 32;
  localparam int HI_W   = NSRC - BANK_W;
  localparam int PID_W  = 6;
  localparam int PIDX_W = $clog2(NSRC);
  localparam int DATA_W = 32;
  localparam int NPORT  = 2;

  localparam int OFF_IP0   = 'h00;
  localparam int OFF_MSK0  = 'h04;
  localparam int OFF_RT0   = 'h08;
  localparam int OFF_FP0   = 'h0C;
  localparam int OFF_PR0   = 'h10;
  localparam int OFF_CTL   = 'h14;
  localparam int OFF_HP    = 'h18;
  localparam int OFF_PLO0  = 'h1C;
  localparam int OFF_PHI0  = 'h98;
  localparam int OFF_IP1   = 'h9C;
  localparam int OFF_MSK1  = 'hA0;
  localparam int OFF_RT1   = 'hA4;
  localparam int OFF_FP1   = 'hA8;
  localparam int OFF_PR1   = 'hAC;
  localparam int OFF_PLO1  = 'hB0;
  localparam int OFF_PHI1  = 'hCC;
  localparam int CP_LAST   = 'hA;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_IP0, SEL_MSK0, SEL_RT0, SEL_FP0, SEL_PR0, SEL_CTL, SEL_HP,
    SEL_PRIO, SEL_IP1, SEL_MSK1, SEL_RT1, SEL_FP1, SEL_PR1
  } sel_e;

  function automatic logic [7:0] cp_to_off(input logic [3:0] idx);
    logic [7:0] o;
    case (idx)
      4'h0: o = 8'(OFF_IP0);
      4'h1: o = 8'(OFF_MSK0);
      4'h2: o = 8'(OFF_RT0);
      4'h3: o = 8'(OFF_FP0);
      4'h4: o = 8'(OFF_PR0);
      4'h5: o = 8'(OFF_HP);
      4'h6: o = 8'(OFF_IP1);
      4'h7: o = 8'(OFF_MSK1);
      4'h8: o = 8'(OFF_RT1);
      4'h9: o = 8'(OFF_FP1);
      4'hA: o = 8'(OFF_PR1);
      default: o = 8'h00;
    endcase
    return o;
  endfunction
endpackage

// File: rtl/intc_bank.sv
module intc_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src_i,
  input  logic         mask_we_i,
  input  logic [W-1:0] mask_d_i,
  input  logic         route_we_i,
  input  logic [W-1:0] route_d_i,
  input  logic         idle_en_i,
  output logic [W-1:0] pend_o,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] route_o,
  output logic [W-1:0] irq_vw_o,
  output logic [W-1:0] fiq_vw_o,
  output logic         irq_any_o,
  output logic         fiq_any_o,
  output logic         wake_any_o
);
  logic [W-1:0] pend_q, mask_q, route_q;
  logic [W-1:0] live;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= '0;
      mask_q  <= '0;
      route_q <= '0;
    end else begin
      pend_q <= src_i;
      if (mask_we_i)  mask_q  <= mask_d_i;
      if (route_we_i) route_q <= route_d_i;
    end
  end

  assign live       = pend_q & mask_q;
  assign irq_vw_o   = live & ~route_q;
  assign fiq_vw_o   = live & route_q;
  assign irq_any_o  = |irq_vw_o;
  assign fiq_any_o  = |fiq_vw_o;
  assign wake_any_o = |(pend_q & (mask_q | {W{idle_en_i}}));
  assign pend_o     = pend_q;
  assign mask_o     = mask_q;
  assign route_o    = route_q;

  p_pend_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> pend_q == $past(src_i));

  p_mask_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mask_we_i && $past(rst_n)) |=> $stable(mask_q));
endmodule

// File: rtl/intc_prio_store.sv
module intc_prio_store #(
  parameter int N   = 40,
  parameter int IW  = 6,
  parameter int NRD = 2,
  parameter int DW  = 32,
  localparam int XW = $clog2(N),
  localparam int EW = IW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [XW-1:0]     widx_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [NRD*XW-1:0] ridx_i,
  output logic [NRD*DW-1:0] rdata_o,
  output logic [N*EW-1:0]   tbl_o
);
  logic [EW-1:0] ent [N];

  for (genvar k = 0; k < N; k++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) ent[k] <= '0;
      else if (we_i && widx_i == XW'(k)) ent[k] <= {wdata_i[DW-1], wdata_i[IW-1:0]};
    end
    assign tbl_o[k*EW +: EW] = ent[k];
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    logic [XW-1:0] ri;
    logic [EW-1:0] e;
    assign ri = ridx_i[p*XW +: XW];
    always_comb begin
      e = '0;
      if (int'(ri) < N) e = ent[ri];
    end
    assign rdata_o[p*DW +: DW] = {e[EW-1], {(DW-EW){1'b0}}, e[IW-1:0]};
  end

  p_prio_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && int'(widx_i) < N) |=>
      tbl_o[$past(widx_i)*EW +: EW] == {$past(wdata_i[DW-1]), $past(wdata_i[IW-1:0])});
endmodule

// File: rtl/intc_addr_dec.sv
module intc_addr_dec
  import intc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              en_i,
  input  logic [ADDR_W-1:0] off_i,
  output sel_e              sel_o,
  output logic [PIDX_W-1:0] pidx_o
);
  always_comb begin
    sel_o  = SEL_NONE;
    pidx_o = '0;
    if (en_i && off_i[1:0] == 2'b00) begin
      case (off_i)
        ADDR_W'(OFF_IP0):  sel_o = SEL_IP0;
        ADDR_W'(OFF_MSK0): sel_o = SEL_MSK0;
        ADDR_W'(OFF_RT0):  sel_o = SEL_RT0;
        ADDR_W'(OFF_FP0):  sel_o = SEL_FP0;
        ADDR_W'(OFF_PR0):  sel_o = SEL_PR0;
        ADDR_W'(OFF_CTL):  sel_o = SEL_CTL;
        ADDR_W'(OFF_HP):   sel_o = SEL_HP;
        ADDR_W'(OFF_IP1):  sel_o = SEL_IP1;
        ADDR_W'(OFF_MSK1): sel_o = SEL_MSK1;
        ADDR_W'(OFF_RT1):  sel_o = SEL_RT1;
        ADDR_W'(OFF_FP1):  sel_o = SEL_FP1;
        ADDR_W'(OFF_PR1):  sel_o = SEL_PR1;
        default: begin
          if (off_i >= ADDR_W'(OFF_PLO0) && off_i <= ADDR_W'(OFF_PHI0)) begin
            sel_o  = SEL_PRIO;
            pidx_o = PIDX_W'((off_i - ADDR_W'(OFF_PLO0)) >> 2);
          end else if (off_i >= ADDR_W'(OFF_PLO1) && off_i <= ADDR_W'(OFF_PHI1)) begin
            sel_o  = SEL_PRIO;
            pidx_o = PIDX_W'(BANK_W + int'((off_i - ADDR_W'(OFF_PLO1)) >> 2));
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/intc_banked40.sv
module intc_banked40
  import intc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NSRC-1:0]     src_i,
  input  logic                core_halted_i,
  input  logic                bus_wr_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [DATA_W-1:0]   bus_wdata_i,
  output logic [DATA_W-1:0]   bus_rdata_o,
  input  logic                cp_wr_i,
  input  logic [3:0]          cp_idx_i,
  input  logic [DATA_W-1:0]   cp_wdata_i,
  output logic [DATA_W-1:0]   cp_rdata_o,
  input  logic [DATA_W-1:0]   hp_word_i,
  output logic [NSRC*(PID_W+1)-1:0] prio_tbl_o,
  output logic                fiq_o,
  output logic                irq_o,
  output logic                wake_o
);
  logic [BANK_W-1:0] b0_pend, b0_mask, b0_route, b0_irq, b0_fiq;
  logic [HI_W-1:0]   b1_pend, b1_mask, b1_route, b1_irq, b1_fiq;
  logic b0_ia, b0_fa, b0_wk, b1_ia, b1_fa, b1_wk;
  logic idle_dis_q;
  logic [NPORT*PIDX_W-1:0] prio_ridx;
  logic [NPORT*DATA_W-1:0] prio_rdat;
  logic [NPORT-1:0][DATA_W-1:0] port_rd;
  sel_e port_sel [NPORT];

  // Port 0 is the byte-addressed port, port 1 the indexed port.
  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic              en;
    logic [ADDR_W-1:0] off;
    logic [PIDX_W-1:0] pidx;
    sel_e              sel;
    logic [DATA_W-1:0] rd;

    if (p == 0) begin : g_bus
      assign en  = 1'b1;
      assign off = bus_addr_i;
    end else begin : g_cp
      assign en  = (int'(cp_idx_i) <= CP_LAST);
      assign off = ADDR_W'(cp_to_off(cp_idx_i));
    end

    intc_addr_dec #(.ADDR_W(ADDR_W)) i_dec (
      .en_i(en), .off_i(off), .sel_o(sel), .pidx_o(pidx)
    );

    assign prio_ridx[p*PIDX_W +: PIDX_W] = pidx;
    assign port_sel[p] = sel;

    always_comb begin
      rd = '0;
      case (sel)
        SEL_IP0:  rd = b0_irq;
        SEL_MSK0: rd = b0_mask;
        SEL_RT0:  rd = b0_route;
        SEL_FP0:  rd = b0_fiq;
        SEL_PR0:  rd = b0_pend;
        SEL_CTL:  rd = DATA_W'(idle_dis_q);
        SEL_HP:   rd = hp_word_i;
        SEL_PRIO: rd = prio_rdat[p*DATA_W +: DATA_W];
        SEL_IP1:  rd = DATA_W'(b1_irq);
        SEL_MSK1: rd = DATA_W'(b1_mask);
        SEL_RT1:  rd = DATA_W'(b1_route);
        SEL_FP1:  rd = DATA_W'(b1_fiq);
        SEL_PR1:  rd = DATA_W'(b1_pend);
        default:  rd = '0;
      endcase
    end
    assign port_rd[p] = rd;
  end

  assign bus_rdata_o = port_rd[0];
  assign cp_rdata_o  = port_rd[1];

  // Write steering: the indexed port wins on a shared target.
  logic m0_we, r0_we, m1_we, r1_we, ctl_we, prio_we;
  logic cp_m0, cp_r0, cp_m1, cp_r1;
  assign cp_m0 = cp_wr_i && port_sel[1] == SEL_MSK0;
  assign cp_r0 = cp_wr_i && port_sel[1] == SEL_RT0;
  assign cp_m1 = cp_wr_i && port_sel[1] == SEL_MSK1;
  assign cp_r1 = cp_wr_i && port_sel[1] == SEL_RT1;
  assign m0_we   = cp_m0 || (bus_wr_i && port_sel[0] == SEL_MSK0);
  assign r0_we   = cp_r0 || (bus_wr_i && port_sel[0] == SEL_RT0);
  assign m1_we   = cp_m1 || (bus_wr_i && port_sel[0] == SEL_MSK1);
  assign r1_we   = cp_r1 || (bus_wr_i && port_sel[0] == SEL_RT1);
  assign ctl_we  = bus_wr_i && port_sel[0] == SEL_CTL;
  assign prio_we = bus_wr_i && port_sel[0] == SEL_PRIO;

  intc_bank #(.W(BANK_W)) i_bank0 (
    .clk(clk), .rst_n(rst_n), .src_i(src_i[BANK_W-1:0]),
    .mask_we_i(m0_we), .mask_d_i(cp_m0 ? cp_wdata_i : bus_wdata_i),
    .route_we_i(r0_we), .route_d_i(cp_r0 ? cp_wdata_i : bus_wdata_i),
    .idle_en_i(!idle_dis_q),
    .pend_o(b0_pend), .mask_o(b0_mask), .route_o(b0_route),
    .irq_vw_o(b0_irq), .fiq_vw_o(b0_fiq),
    .irq_any_o(b0_ia), .fiq_any_o(b0_fa), .wake_any_o(b0_wk)
  );

  intc_bank #(.W(HI_W)) i_bank1 (
    .clk(clk), .rst_n(rst_n), .src_i(src_i[NSRC-1:BANK_W]),
    .mask_we_i(m1_we), .mask_d_i(cp_m1 ? cp_wdata_i[HI_W-1:0] : bus_wdata_i[HI_W-1:0]),
    .route_we_i(r1_we), .route_d_i(cp_r1 ? cp_wdata_i[HI_W-1:0] : bus_wdata_i[HI_W-1:0]),
    .idle_en_i(!idle_dis_q),
    .pend_o(b1_pend), .mask_o(b1_mask), .route_o(b1_route),
    .irq_vw_o(b1_irq), .fiq_vw_o(b1_fiq),
    .irq_any_o(b1_ia), .fiq_any_o(b1_fa), .wake_any_o(b1_wk)
  );

  intc_prio_store #(.N(NSRC), .IW(PID_W), .NRD(NPORT), .DW(DATA_W)) i_prio (
    .clk(clk), .rst_n(rst_n), .we_i(prio_we),
    .widx_i(prio_ridx[PIDX_W-1:0]), .wdata_i(bus_wdata_i),
    .ridx_i(prio_ridx), .rdata_o(prio_rdat), .tbl_o(prio_tbl_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      idle_dis_q <= 1'b1;
    else if (ctl_we) idle_dis_q <= bus_wdata_i[0];
  end

  assign fiq_o  = b0_fa | b1_fa;
  assign irq_o  = b0_ia | b1_ia;
  assign wake_o = core_halted_i & (b0_wk | b1_wk);

  p_fiq_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o == ((|(b0_pend & b0_mask & b0_route)) || (|(b1_pend & b1_mask & b1_route))));

  p_irq_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == ((|(b0_pend & b0_mask & ~b0_route)) || (|(b1_pend & b1_mask & ~b1_route))));

  p_wake_halt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> core_halted_i);

  p_ctl_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_i && bus_addr_i == ADDR_W'(OFF_CTL)) |=> idle_dis_q == $past(bus_wdata_i[0]));

  p_cp_unmapped_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_wr_i && int'(cp_idx_i) > CP_LAST && !bus_wr_i) |=>
      ($stable(b0_mask) && $stable(b0_route) && $stable(b1_mask) && $stable(b1_route)));

  p_ro_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_i && !cp_wr_i && (bus_addr_i == ADDR_W'(OFF_PR0) || bus_addr_i == ADDR_W'(OFF_HP))) |=>
      ($stable(b0_mask) && $stable(b0_route) && $stable(idle_dis_q)));

  p_cp_wins_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_i && cp_wr_i && bus_addr_i == ADDR_W'(OFF_MSK0) && cp_idx_i == 4'h1) |=>
      b0_mask == $past(cp_wdata_i));
endmodule

// File: tb/test_intc_banked40.sv
module test_intc_banked40;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [39:0] src = '0;
  logic        halted = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        cp_wr = 1'b0;
  logic [3:0]  cp_idx = '0;
  logic [31:0] cp_wdata = '0;
  logic [31:0] cp_rdata;
  logic [31:0] hp_word = '0;
  logic [279:0] prio_tbl;
  logic fiq, irq, wake;
  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intc_banked40 i_intc_banked40 (
    .clk(clk), .rst_n(rst_n), .src_i(src), .core_halted_i(halted),
    .bus_wr_i(bus_wr), .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .cp_wr_i(cp_wr), .cp_idx_i(cp_idx), .cp_wdata_i(cp_wdata), .cp_rdata_o(cp_rdata),
    .hp_word_i(hp_word), .prio_tbl_o(prio_tbl), .fiq_o(fiq), .irq_o(irq), .wake_o(wake)
  );

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic bwr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic cwr(input logic [3:0] i, input logic [31:0] d);
    @(negedge clk);
    cp_idx = i; cp_wdata = d; cp_wr = 1'b1;
    @(negedge clk);
    cp_wr = 1'b0;
  endtask

  task automatic brd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    chk(req, $sformatf("read 0x%02h", a), bus_rdata, exp);
  endtask

  task automatic crd_chk(input string req, input logic [3:0] i, input logic [31:0] exp);
    cp_idx = i;
    #1;
    chk(req, $sformatf("cp index 0x%0h", i), cp_rdata, exp);
  endtask

  task automatic set_src(input logic [39:0] v);
    @(negedge clk);
    src = v;
    @(negedge clk);
  endtask

  task automatic t_reset;
    brd_chk("R9", 8'h10, 32'h0);
    brd_chk("R9", 8'h04, 32'h0);
    brd_chk("R9", 8'hA4, 32'h0);
    brd_chk("R9", 8'h98, 32'h0);
    brd_chk("R6", 8'h14, 32'h1);
    chk("R9", "fiq/irq/wake", {29'b0, fiq, irq, wake}, 32'h0);
  endtask

  task automatic t_pending;
    @(negedge clk);
    src = (40'h1 << 3) | (40'h1 << 35);
    bus_addr = 8'h10;
    #1;
    chk("R2", "raw0 before edge", bus_rdata, 32'h0);
    @(negedge clk);
    brd_chk("R1", 8'h10, 32'h0000_0008);
    brd_chk("R1", 8'hAC, 32'h0000_0008);
    set_src('0);
    brd_chk("R2", 8'h10, 32'h0);
    brd_chk("R2", 8'hAC, 32'h0);
  endtask

  task automatic t_views;
    bwr(8'h04, 32'hF);
    bwr(8'h08, 32'h5);
    brd_chk("R3", 8'h04, 32'hF);
    brd_chk("R3", 8'h08, 32'h5);
    set_src(40'hF);
    brd_chk("R4", 8'h00, 32'hA);
    brd_chk("R4", 8'h0C, 32'h5);
    chk("R5", "fiq,irq both", {30'b0, fiq, irq}, 32'h3);
    bwr(8'h04, 32'hA);
    chk("R5", "fiq,irq no fast", {30'b0, fiq, irq}, 32'h1);
    bwr(8'h04, 32'h0);
    bwr(8'hA0, 32'hFFFF_FF81);
    brd_chk("R3", 8'hA0, 32'h81);
    bwr(8'hA4, 32'h80);
    set_src(40'h81_0000_0000);
    brd_chk("R4", 8'hA8, 32'h80);
    brd_chk("R4", 8'h9C, 32'h01);
    chk("R5", "fiq,irq bank1", {30'b0, fiq, irq}, 32'h3);
    set_src('0);
    chk("R5", "fiq,irq idle", {30'b0, fiq, irq}, 32'h0);
    bwr(8'hA0, 32'h0);
    bwr(8'hA4, 32'h0);
    bwr(8'h08, 32'h0);
  endtask

  task automatic t_wake;
    set_src(40'h1 << 5);
    #1;
    chk("R7", "wake not halted", {31'b0, wake}, 32'h0);
    halted = 1'b1;
    #1;
    chk("R7", "wake halted, masked, no override", {31'b0, wake}, 32'h0);
    bwr(8'h14, 32'h0);
    brd_chk("R6", 8'h14, 32'h0);
    chk("R7", "wake override", {31'b0, wake}, 32'h1);
    bwr(8'h14, 32'h1);
    brd_chk("R6", 8'h14, 32'h1);
    chk("R7", "wake override off", {31'b0, wake}, 32'h0);
    bwr(8'h04, 32'h20);
    chk("R7", "wake enabled", {31'b0, wake}, 32'h1);
    halted = 1'b0;
    #1;
    chk("R7", "wake released", {31'b0, wake}, 32'h0);
    bwr(8'h04, 32'h0);
    set_src('0);
  endtask

  task automatic t_prio;
    bwr(8'h1C, 32'hFFFF_FFFF);
    brd_chk("R8", 8'h1C, 32'h8000_003F);
    bwr(8'h98, 32'h8000_0107);
    brd_chk("R8", 8'h98, 32'h8000_0007);
    bwr(8'hB0, 32'h0000_0022);
    brd_chk("R8", 8'hB0, 32'h0000_0022);
    bwr(8'hCC, 32'h1234_5678);
    brd_chk("R8", 8'hCC, 32'h0000_0038);
    chk("R8", "table entry 39", {25'b0, prio_tbl[39*7 +: 7]}, 32'h38);
    chk("R8", "table entry 0", {25'b0, prio_tbl[0 +: 7]}, 32'h7F);
  endtask

  task automatic t_cp;
    cwr(4'h1, 32'h0000_0300);
    brd_chk("R10", 8'h04, 32'h300);
    cwr(4'h8, 32'h0000_0002);
    brd_chk("R10", 8'hA4, 32'h2);
    cwr(4'hC, 32'hFFFF_FFFF);
    brd_chk("R10", 8'h04, 32'h300);
    brd_chk("R10", 8'hA4, 32'h2);
    crd_chk("R10", 4'hC, 32'h0);
    set_src(40'h300);
    crd_chk("R10", 4'h4, 32'h300);
    crd_chk("R10", 4'h0, 32'h300);
    crd_chk("R10", 4'h2, 32'h0);
    hp_word = 32'h8005_0003;
    crd_chk("R12", 4'h5, 32'h8005_0003);
    brd_chk("R12", 8'h18, 32'h8005_0003);
    set_src('0);
    cwr(4'h1, 32'h0);
    cwr(4'h8, 32'h0);
  endtask

  task automatic t_undef;
    bwr(8'h05, 32'hFFFF_FFFF);
    bwr(8'hD0, 32'hFFFF_FFFF);
    bwr(8'h10, 32'hFFFF_FFFF);
    bwr(8'h00, 32'hFFFF_FFFF);
    bwr(8'h18, 32'hFFFF_FFFF);
    brd_chk("R11", 8'h04, 32'h0);
    brd_chk("R11", 8'h08, 32'h0);
    brd_chk("R11", 8'h14, 32'h1);
    brd_chk("R11", 8'hD0, 32'h0);
    brd_chk("R11", 8'h05, 32'h0);
    set_src(40'h1);
    brd_chk("R11", 8'h10, 32'h1);
    chk("R11", "irq after ignored writes", {31'b0, irq}, 32'h0);
    set_src('0);
  endtask

  task automatic t_both;
    @(negedge clk);
    bus_addr = 8'h04; bus_wdata = 32'h1; bus_wr = 1'b1;
    cp_idx = 4'h1; cp_wdata = 32'h2; cp_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; cp_wr = 1'b0;
    brd_chk("R13", 8'h04, 32'h2);
    @(negedge clk);
    bus_addr = 8'h04; bus_wdata = 32'h10; bus_wr = 1'b1;
    cp_idx = 4'h2; cp_wdata = 32'h20; cp_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; cp_wr = 1'b0;
    brd_chk("R13", 8'h04, 32'h10);
    brd_chk("R13", 8'h08, 32'h20);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pending();
    t_views();
    t_wake();
    t_prio();
    t_cp();
    t_undef();
    t_both();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule